// File: doc/BRIEF.md
# Endpoint Buffer DMA Request Sequencer

This block keeps one data-request flag per bulk endpoint, set when the packet buffer needs service and cleared by software or by hardware. The buffer needs service when an OUT packet has arrived or when the send buffer is free for the next IN packet. The flag drives the DMA engine's request line and, through an enable, a CPU interrupt. The block serves endpoints 1 to NUM_EP. Bit 0 of every vector is endpoint 1. The control endpoint has no slot.

There are two modes per endpoint. In packet mode, the flag holds after each packet until software clears it, and the interrupt follows the flag. In automatic-size mode, DMA must also be enabled. Software loads a total byte count once. The block then counts the 16-bit DMA accesses and drops the flag by itself when one packet's worth of bytes has moved. It repeats this for every packet and raises the CPU interrupt only after the last halfword of the total. An odd total leaves one byte over. The block reports it, and software moves that byte with a byte access to the low-order data byte.

Top module: `dma_req_seq`

## Requirements
- R1: After reset, req_o, irq_o and odd_tail_o are all 0.
- R2: A buf_evt_i pulse sets that endpoint's req_o in the next cycle. A buf_evt_i and sw_clr_i on the same endpoint in the same cycle leave req_o at 1.
- R3: In packet mode (auto_mode_i=0, or dma_en_i=0), req_o stays 1 until sw_clr_i. DMA accesses neither clear it nor change the byte counters.
- R4: In automatic mode (auto_mode_i=1 and dma_en_i=1), req_o falls in the cycle after the access that brings the bytes moved in the current packet to pkt_size_i.
- R5: A total_load_i pulse loads the remaining-byte count from total_bytes_i and zeroes the packet byte count. Each accepted automatic-mode access moves 2 bytes.
- R6: A dma_acc_i pulse while req_o is 0 is ignored and moves no bytes.
- R7: In automatic mode, the access that leaves 0 or 1 byte remaining also clears req_o, even in a short packet. It sets a done state that holds until sw_clr_i or total_load_i.
- R8: irq_o is req_o AND irq_en_i in packet mode, and done AND irq_en_i in automatic mode.
- R9: odd_tail_o is 1 while the done state holds with exactly one byte remaining.
- R10: Endpoints are independent: stimulus on one endpoint changes no output bit of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| auto_mode_i | input | NUM_EP | 1 selects automatic-size mode for the endpoint |
| dma_en_i | input | NUM_EP | DMA enable for the endpoint |
| irq_en_i | input | NUM_EP | Request-interrupt enable for the endpoint |
| pkt_size_i | input | NUM_EP x SIZE_W | Packet size in bytes for each endpoint |
| total_bytes_i | input | CNT_W | Total byte count for the next load |
| total_load_i | input | NUM_EP | Pulse that loads total_bytes_i into the endpoint |
| buf_evt_i | input | NUM_EP | Buffer-ready pulse from the USB engine (OUT packet received, or IN buffer free) |
| dma_acc_i | input | NUM_EP | DMA halfword access pulse |
| sw_clr_i | input | NUM_EP | Software clear of the request and done state |
| req_o | output | NUM_EP | Data-request flag per endpoint |
| irq_o | output | NUM_EP | CPU interrupt per endpoint |
| odd_tail_o | output | NUM_EP | One byte remains for a CPU byte access |

## Verification
The bench uses five endpoints, 12-bit totals and 7-bit packet sizes. It sets every packet size to 4 bytes, so a 10-byte automatic transfer crosses two full packets and a short last one in a handful of cycles. A packet-mode endpoint and an automatic endpoint run side by side. This exposes both kinds of fault: an ignored access that is wrongly counted, which brings the completion interrupt one packet early, and a clear that crosses into the wrong endpoint or mode. A 5-byte total reaches the odd-byte tail.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int unsigned HW_BYTES = 2;  // bytes per DMA access
  typedef enum logic [1:0] {
    REQ_HOLD = 2'd0,
    REQ_SET  = 2'd1,
    REQ_CLR  = 2'd2
  } req_act_e;
endpackage

// File: rtl/dma_byte_ctr.sv
module dma_byte_ctr
  import dma_seq_pkg::*;
#(
  parameter int unsigned SIZE_W = 7,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  input  logic              acc_i,       // accepted automatic-mode access
  input  logic [SIZE_W-1:0] pkt_size_i,
  output logic              pkt_end_o,
  output logic              xfer_end_o,
  output logic [CNT_W-1:0]  rem_o
);
  localparam logic [SIZE_W:0] PKT_STEP = (SIZE_W+1)'(HW_BYTES);
  localparam logic [CNT_W-1:0] REM_STEP = CNT_W'(HW_BYTES);
  localparam logic [CNT_W-1:0] REM_LAST = CNT_W'(2*HW_BYTES - 1);

  logic [SIZE_W-1:0] pkt_cnt_q;
  logic [CNT_W-1:0]  rem_q;
  logic [SIZE_W:0]   pkt_next;
  logic              can_step;

  assign pkt_next   = {1'b0, pkt_cnt_q} + PKT_STEP;
  assign can_step   = rem_q >= REM_STEP;
  assign xfer_end_o = acc_i && can_step && (rem_q <= REM_LAST);
  assign pkt_end_o  = acc_i && ((pkt_next >= {1'b0, pkt_size_i}) || xfer_end_o);
  assign rem_o      = rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q     <= '0;
      pkt_cnt_q <= '0;
    end else if (load_i) begin
      rem_q     <= load_val_i;
      pkt_cnt_q <= '0;
    end else if (acc_i) begin
      if (can_step) rem_q <= rem_q - REM_STEP;
      pkt_cnt_q <= pkt_end_o ? '0 : pkt_next[SIZE_W-1:0];
    end
  end

  a_r5_halfword_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && can_step && !load_i) |=> (rem_q == $past(rem_q) - REM_STEP));
  a_r6_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !load_i) |=> $stable(rem_q));
  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pkt_cnt_q == '0));
endmodule

// File: rtl/dma_req_flag.sv
module dma_req_flag
  import dma_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic sw_clr_i,
  input  logic auto_act_i,
  input  logic pkt_end_i,
  input  logic xfer_end_i,
  input  logic load_i,
  input  logic irq_en_i,
  output logic req_o,
  output logic done_o,
  output logic irq_o
);
  logic     req_q, done_q;
  req_act_e act;

  always_comb begin
    if (evt_i)                         act = REQ_SET;  // new buffer event wins
    else if (sw_clr_i)                 act = REQ_CLR;
    else if (auto_act_i && pkt_end_i)  act = REQ_CLR;
    else                               act = REQ_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (act)
        REQ_SET: req_q <= 1'b1;
        REQ_CLR: req_q <= 1'b0;
        default: req_q <= req_q;
      endcase
      if (sw_clr_i || load_i)            done_q <= 1'b0;
      else if (auto_act_i && xfer_end_i) done_q <= 1'b1;
    end
  end

  assign req_o  = req_q;
  assign done_o = done_q;
  assign irq_o  = irq_en_i && (auto_act_i ? done_q : req_q);

  a_r2_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> req_q);
  a_r3_pkt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && !auto_act_i && !sw_clr_i) |=> req_q);
  a_r7_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !sw_clr_i && !load_i) |=> done_q);
endmodule

// File: rtl/dma_req_seq.sv
module dma_req_seq #(
  parameter int unsigned NUM_EP = 5,
  parameter int unsigned SIZE_W = 7,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_EP-1:0]              auto_mode_i,
  input  logic [NUM_EP-1:0]              dma_en_i,
  input  logic [NUM_EP-1:0]              irq_en_i,
  input  logic [NUM_EP-1:0][SIZE_W-1:0]  pkt_size_i,
  input  logic [CNT_W-1:0]               total_bytes_i,
  input  logic [NUM_EP-1:0]              total_load_i,
  input  logic [NUM_EP-1:0]              buf_evt_i,
  input  logic [NUM_EP-1:0]              dma_acc_i,
  input  logic [NUM_EP-1:0]              sw_clr_i,
  output logic [NUM_EP-1:0]              req_o,
  output logic [NUM_EP-1:0]              irq_o,
  output logic [NUM_EP-1:0]              odd_tail_o
);
  localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic             auto_act, acc, pkt_end, xfer_end, done;
    logic [CNT_W-1:0] rem;

    assign auto_act = auto_mode_i[e] && dma_en_i[e];
    assign acc      = dma_acc_i[e] && req_o[e] && auto_act;

    dma_byte_ctr #(.SIZE_W(SIZE_W), .CNT_W(CNT_W)) i_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (total_load_i[e]),
      .load_val_i (total_bytes_i),
      .acc_i      (acc),
      .pkt_size_i (pkt_size_i[e]),
      .pkt_end_o  (pkt_end),
      .xfer_end_o (xfer_end),
      .rem_o      (rem)
    );

    dma_req_flag i_flag (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (buf_evt_i[e]),
      .sw_clr_i   (sw_clr_i[e]),
      .auto_act_i (auto_act),
      .pkt_end_i  (pkt_end),
      .xfer_end_i (xfer_end),
      .load_i     (total_load_i[e]),
      .irq_en_i   (irq_en_i[e]),
      .req_o      (req_o[e]),
      .done_o     (done),
      .irq_o      (irq_o[e])
    );

    assign odd_tail_o[e] = done && (rem == ONE_LEFT);

    a_r7_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done) |-> (rem <= ONE_LEFT));
    a_r4_auto_only_hw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o[e] && !buf_evt_i[e] && !sw_clr_i[e] && !dma_acc_i[e]) |=> req_o[e]);
  end
endmodule

// File: tb/test_dma_req_seq.sv
module test_dma_req_seq;
  localparam int NUM_EP = 5;
  localparam int SIZE_W = 7;
  localparam int CNT_W  = 12;
  localparam int NV     = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NUM_EP-1:0] auto_mode, dma_en, irq_en, load, evt, acc, clr;
  logic [NUM_EP-1:0][SIZE_W-1:0] pkt_size;
  logic [CNT_W-1:0] total;
  logic [NUM_EP-1:0] req, irq, odd;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dma_req_seq #(.NUM_EP(NUM_EP), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) i_dma_req_seq (
    .clk_i(clk), .rst_ni(rst_ni), .auto_mode_i(auto_mode), .dma_en_i(dma_en),
    .irq_en_i(irq_en), .pkt_size_i(pkt_size), .total_bytes_i(total),
    .total_load_i(load), .buf_evt_i(evt), .dma_acc_i(acc), .sw_clr_i(clr),
    .req_o(req), .irq_o(irq), .odd_tail_o(odd)
  );

  // {evt, acc, clr, load, exp_req, exp_irq}; ep0 packet mode, ep1 auto, pkt 4, total 10
  localparam logic [29:0] VEC [NV] = '{
    {5'b00000, 5'b00000, 5'b00000, 5'b00010, 5'b00000, 5'b00000}, // R5 load
    {5'b00011, 5'b00000, 5'b00000, 5'b00000, 5'b00011, 5'b00001}, // R2 R8 R10
    {5'b00000, 5'b00011, 5'b00000, 5'b00000, 5'b00011, 5'b00001}, // R3 hold
    {5'b00000, 5'b00010, 5'b00000, 5'b00000, 5'b00001, 5'b00001}, // R4 packet full
    {5'b00000, 5'b00010, 5'b00000, 5'b00000, 5'b00001, 5'b00001}, // R6 ignored
    {5'b00000, 5'b00000, 5'b00001, 5'b00000, 5'b00000, 5'b00000}, // R3 sw clear
    {5'b00010, 5'b00000, 5'b00000, 5'b00000, 5'b00010, 5'b00000},
    {5'b00000, 5'b00010, 5'b00000, 5'b00000, 5'b00010, 5'b00000},
    {5'b00000, 5'b00010, 5'b00000, 5'b00000, 5'b00000, 5'b00000}, // R4 second packet
    {5'b00010, 5'b00000, 5'b00000, 5'b00000, 5'b00010, 5'b00000},
    {5'b00000, 5'b00010, 5'b00000, 5'b00000, 5'b00000, 5'b00010}, // R7 short last
    {5'b00000, 5'b00000, 5'b00010, 5'b00000, 5'b00000, 5'b00000}  // R7 done cleared
  };

  task automatic cyc(input logic [NUM_EP-1:0] e, a, c, l);
    evt = e; acc = a; clr = c; load = l;
    @(posedge clk); #1;
    evt = '0; acc = '0; clr = '0; load = '0;
  endtask

  task automatic chk(input string tag, input logic [NUM_EP-1:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    auto_mode = 5'b00110; dma_en = '1; irq_en = '1;
    for (int i = 0; i < NUM_EP; i++) pkt_size[i] = SIZE_W'(4);
    total = CNT_W'(10);
    evt = '0; acc = '0; clr = '0; load = '0;
    #10; rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1 req", req, '0);
    chk("R1 irq", irq, '0);
    chk("R1 odd", odd, '0);

    for (int v = 0; v < NV; v++) begin
      cyc(VEC[v][29:25], VEC[v][24:20], VEC[v][19:15], VEC[v][14:10]);
      n_chk++;
      if (req !== VEC[v][9:5] || irq !== VEC[v][4:0]) begin
        n_bad++;
        $display("FAIL table vec %0d (R2/R3/R4/R5/R6/R7/R8/R10) actual=%b/%b expected=%b/%b",
                 v, req, irq, VEC[v][9:5], VEC[v][4:0]);
      end
    end

    // R2 set beats clear
    cyc(5'b00001, '0, 5'b00001, '0);
    chk("R2 set-over-clear", req, 5'b00001);
    cyc('0, '0, 5'b00001, '0);

    // R8 enable gating in packet mode
    irq_en[0] = 1'b0;
    cyc(5'b00001, '0, '0, '0);
    chk("R8 gated req", req, 5'b00001);
    chk("R8 gated irq", irq, 5'b00000);
    cyc('0, '0, 5'b00001, '0);
    irq_en[0] = 1'b1;

    // R3 auto endpoint with DMA disabled behaves as packet mode
    dma_en[1] = 1'b0;
    cyc('0, '0, '0, 5'b00010);
    cyc(5'b00010, '0, '0, '0);
    cyc('0, 5'b00010, '0, '0);
    cyc('0, 5'b00010, '0, '0);
    chk("R3 dma off req", req, 5'b00010);
    chk("R3 dma off irq", irq, 5'b00010);
    cyc('0, '0, 5'b00010, '0);
    dma_en[1] = 1'b1;

    // R9 odd total on ep2: 5 bytes, packet 4
    total = CNT_W'(5);
    cyc('0, '0, '0, 5'b00100);
    cyc(5'b00100, '0, '0, '0);
    cyc('0, 5'b00100, '0, '0);
    chk("R4 mid packet req", req, 5'b00100);
    cyc('0, 5'b00100, '0, '0);
    chk("R7 odd req", req, 5'b00000);
    chk("R7 odd irq", irq, 5'b00100);
    chk("R9 odd tail", odd, 5'b00100);
    cyc('0, '0, '0, 5'b00100);
    chk("R7 load clears done", irq, 5'b00000);
    chk("R9 tail cleared", odd, 5'b00000);

    // R1 reset in mid-run
    cyc(5'b11111, '0, '0, '0);
    rst_ni = 1'b0; #3;
    chk("R1 async req", req, '0);
    @(posedge clk); #1; rst_ni = 1'b1;
    chk("R1 async irq", irq, '0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule